// File: doc/BRIEF.md
# Demand miss latency estimator

This block measures how long demand misses take to come back from the memory level below the L2 cache, and it keeps a smoothed figure for use by a prefetch-offset evaluator. Each demand miss whose line tag is new is recorded with a 16-bit timestamp taken from a free-running cycle counter. The records sit in a small shadow table that is kept in age order. When a fill arrives for a recorded line, the elapsed time is measured, truncated to 10 bits, and pushed into a sliding window of recent samples. The record is then dropped.

The average output starts at a fixed default of 100 cycles. It is first replaced once the window holds a full set of samples. From then on it is refreshed with every new sample, as the window sum divided by the window length by means of a right shift. The tags in the shadow table are also brought out so that a neighbouring block can check for duplicates. The inputs are line tags, meaning line addresses that are already truncated, together with the cycle counter. Cache behaviour and prefetch decisions are handled elsewhere.

Top module: `lat_est_top`

## Requirements
- R1: After reset the table is empty (all of `tbl_valid` low) and `avg_latency` reads 100.
- R2: A miss whose tag is not in the table stores the tag, with `now_cycle` as its stamp, in the first free slot. Slot 0 always holds the oldest entry and the valid slots are contiguous from slot 0. Slot i occupies bits [16*i+15:16*i] of `tbl_tags`.
- R3: A miss whose tag is already in the table changes neither the table nor its stamps. No tag is ever held twice.
- R4: A new-tag miss on a table that is full (16 entries) discards the entry in slot 0. Every other entry moves one slot toward slot 0, and the new entry goes into slot 15.
- R5: A fill whose tag matches an entry removes that entry. All younger entries move one slot toward slot 0 and keep their order.
- R6: A fill whose tag matches no entry leaves the table and `avg_latency` unchanged.
- R7: The latency sample of a matching fill is (`now_cycle` at the fill minus the stamp) modulo 65536, keeping only the low 10 bits (modulo 1024).
- R8: `avg_latency` stays at 100 until 32 samples have been collected. On the clock edge that stores the 32nd sample, it becomes the sum of the 32 samples shifted right by 5.
- R9: After the first 32 samples, each new sample replaces the oldest one in the window. `avg_latency` is updated on that edge to the new sum shifted right by 5, and it does not change on any cycle without a sample.
- R10: If a miss and a fill arrive in the same cycle, the fill is applied to the table first. The miss is then checked for duplicates against the table that results. A miss and a fill on the same tag therefore measure the old record and leave a fresh record in the youngest slot, stamped with the current `now_cycle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss event this cycle |
| miss_tag | input | 16 | Line tag of the demand miss |
| fill_valid | input | 1 | Fill event this cycle |
| fill_tag | input | 16 | Line tag of the fill |
| now_cycle | input | 16 | Free-running cycle counter |
| avg_latency | output | 16 | Current average miss latency in cycles |
| tbl_valid | output | 16 | Valid bit per table slot, slot 0 oldest |
| tbl_tags | output | 256 | Tag per table slot, 16 bits each |

## Verification
A miss and a fill can reach the table in the same cycle, so the bench drives both strobes together in two forms. In the first, both carry the same tag, which exposes whether the fill's removal is applied before the miss is checked for duplicates. In the second, the tags differ, and one record leaves while another is added. A bench-side queue model resolves every such cycle in the required order: remove first, then append, with an overflow drop if needed. After each cycle the model is compared against the full slot-ordered tag image and against the average. A long mixed sweep over a small tag space also produces coincident events together with duplicates, overflow and compaction.

// File: rtl/lat_est_pkg.sv
package lat_est_pkg;

   // What the miss side does to the table in one cycle
   typedef enum logic [1:0] {
      TBL_HOLD        = 2'd0,
      TBL_APPEND      = 2'd1,
      TBL_SHIFT_APPND = 2'd2
   } tbl_act_e;

   localparam int unsigned DEF_TAG_W     = 16;
   localparam int unsigned DEF_STAMP_W   = 16;
   localparam int unsigned DEF_DEPTH     = 16;
   localparam int unsigned DEF_LAT_W     = 10;
   localparam int unsigned DEF_WIN       = 32;
   localparam int unsigned DEF_AVG_W     = 16;
   localparam int unsigned DEF_AVG_RESET = 100;

endpackage

// File: rtl/lat_est_miss_table.sv
module lat_est_miss_table
   import lat_est_pkg::*;
#(
   parameter int unsigned TAG_W   = DEF_TAG_W,
   parameter int unsigned STAMP_W = DEF_STAMP_W,
   parameter int unsigned DEPTH   = DEF_DEPTH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     miss_valid,
   input  logic [TAG_W-1:0]         miss_tag,
   input  logic                     fill_valid,
   input  logic [TAG_W-1:0]         fill_tag,
   input  logic [STAMP_W-1:0]       now_cycle,
   output logic                     fill_hit,
   output logic [STAMP_W-1:0]       fill_stamp,
   output logic [DEPTH-1:0]         ent_valid,
   output logic [DEPTH*TAG_W-1:0]   ent_tags
);

   logic [TAG_W-1:0]   tag_q   [DEPTH];
   logic [STAMP_W-1:0] stamp_q [DEPTH];
   logic [DEPTH-1:0]   vld_q;

   // fill lookup
   logic [DEPTH-1:0]   hit_vec;
   logic [DEPTH-1:0]   at_or_after;   // slot index >= oldest hit
   logic [DEPTH-1:0]   first_hit;

   // table after removal
   logic [TAG_W-1:0]   s1_tag   [DEPTH];
   logic [STAMP_W-1:0] s1_stamp [DEPTH];
   logic [DEPTH-1:0]   s1_vld;

   // miss side
   logic [DEPTH-1:0]   dup_vec;
   logic [DEPTH-1:0]   free_slot;
   tbl_act_e           act;

   logic [TAG_W-1:0]   nx_tag   [DEPTH];
   logic [STAMP_W-1:0] nx_stamp [DEPTH];
   logic [DEPTH-1:0]   nx_vld;

   for (genvar i = 0; i < DEPTH; i++) begin : g_lookup
      assign hit_vec[i] = fill_valid && vld_q[i] && (tag_q[i] == fill_tag);
      if (i == 0) begin : g_head
         assign at_or_after[i] = hit_vec[i];
         assign first_hit[i]   = hit_vec[i];
      end else begin : g_body
         assign at_or_after[i] = hit_vec[i] | at_or_after[i-1];
         assign first_hit[i]   = hit_vec[i] & ~at_or_after[i-1];
      end
   end

   assign fill_hit = |hit_vec;

   always_comb begin
      fill_stamp = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (first_hit[i]) fill_stamp = fill_stamp | stamp_q[i];
      end
   end

   // compaction: from the removed slot upward every slot takes its younger neighbour
   for (genvar i = 0; i < DEPTH; i++) begin : g_compact
      if (i < DEPTH-1) begin : g_mid
         assign s1_tag[i]   = at_or_after[i] ? tag_q[i+1]   : tag_q[i];
         assign s1_stamp[i] = at_or_after[i] ? stamp_q[i+1] : stamp_q[i];
         assign s1_vld[i]   = at_or_after[i] ? vld_q[i+1]   : vld_q[i];
      end else begin : g_top
         assign s1_tag[i]   = at_or_after[i] ? '0   : tag_q[i];
         assign s1_stamp[i] = at_or_after[i] ? '0   : stamp_q[i];
         assign s1_vld[i]   = at_or_after[i] ? 1'b0 : vld_q[i];
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_dup
      assign dup_vec[i] = s1_vld[i] && (s1_tag[i] == miss_tag);
      if (i == 0) begin : g_head
         assign free_slot[i] = ~s1_vld[i];
      end else begin : g_body
         assign free_slot[i] = ~s1_vld[i] & s1_vld[i-1];
      end
   end

   always_comb begin
      if (!miss_valid || (|dup_vec))   act = TBL_HOLD;
      else if (s1_vld[DEPTH-1])        act = TBL_SHIFT_APPND;
      else                             act = TBL_APPEND;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_next
      always_comb begin
         nx_tag[i]   = s1_tag[i];
         nx_stamp[i] = s1_stamp[i];
         nx_vld[i]   = s1_vld[i];
         unique case (act)
            TBL_APPEND: begin
               if (free_slot[i]) begin
                  nx_tag[i]   = miss_tag;
                  nx_stamp[i] = now_cycle;
                  nx_vld[i]   = 1'b1;
               end
            end
            TBL_SHIFT_APPND: begin
               if (i == DEPTH-1) begin
                  nx_tag[i]   = miss_tag;
                  nx_stamp[i] = now_cycle;
                  nx_vld[i]   = 1'b1;
               end else begin
                  nx_tag[i]   = s1_tag[(i+1) % DEPTH];
                  nx_stamp[i] = s1_stamp[(i+1) % DEPTH];
                  nx_vld[i]   = s1_vld[(i+1) % DEPTH];
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]   <= '0;
            stamp_q[i] <= '0;
         end
      end else begin
         vld_q <= nx_vld;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]   <= nx_tag[i];
            stamp_q[i] <= nx_stamp[i];
         end
      end
   end

   assign ent_valid = vld_q;
   for (genvar i = 0; i < DEPTH; i++) begin : g_out
      assign ent_tags[i*TAG_W +: TAG_W] = tag_q[i];
   end

endmodule

// File: rtl/lat_est_window.sv
module lat_est_window
   import lat_est_pkg::*;
#(
   parameter int unsigned LAT_W     = DEF_LAT_W,
   parameter int unsigned WIN       = DEF_WIN,
   parameter int unsigned AVG_W     = DEF_AVG_W,
   parameter int unsigned AVG_RESET = DEF_AVG_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [LAT_W-1:0]  sample,
   output logic [AVG_W-1:0]  avg,
   output logic              full
);

   localparam int unsigned PTR_W = $clog2(WIN);
   localparam int unsigned CNT_W = PTR_W + 1;
   localparam int unsigned ACC_W = LAT_W + PTR_W;
   localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN);
   localparam logic [CNT_W-1:0] WIN_M1 = CNT_W'(WIN - 1);

   logic [LAT_W-1:0] smp_q [WIN];
   logic [PTR_W-1:0] wr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ACC_W-1:0] acc_q;
   logic [AVG_W-1:0] avg_q;

   logic [LAT_W-1:0] evict;
   logic [ACC_W-1:0] acc_nx;
   logic             full_nx;
   logic [ACC_W-1:0] quot;

   assign evict   = (cnt_q == WIN_C) ? smp_q[wr_q] : '0;
   assign acc_nx  = acc_q + ACC_W'(sample) - ACC_W'(evict);
   assign full_nx = (cnt_q == WIN_C) || (cnt_q == WIN_M1);
   assign quot    = acc_nx >> PTR_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         cnt_q <= '0;
         acc_q <= '0;
         avg_q <= AVG_W'(AVG_RESET);
      end else if (push) begin
         wr_q  <= wr_q + 1'b1;
         acc_q <= acc_nx;
         if (cnt_q != WIN_C) cnt_q <= cnt_q + 1'b1;
         if (full_nx)        avg_q <= AVG_W'(quot);
      end
   end

   always_ff @(posedge clk) begin
      if (push) smp_q[wr_q] <= sample;
   end

   assign avg  = avg_q;
   assign full = (cnt_q == WIN_C);

endmodule

// File: rtl/lat_est_top.sv
module lat_est_top
   import lat_est_pkg::*;
#(
   parameter int unsigned TAG_W     = DEF_TAG_W,
   parameter int unsigned STAMP_W   = DEF_STAMP_W,
   parameter int unsigned DEPTH     = DEF_DEPTH,
   parameter int unsigned LAT_W     = DEF_LAT_W,
   parameter int unsigned WIN       = DEF_WIN,
   parameter int unsigned AVG_W     = DEF_AVG_W,
   parameter int unsigned AVG_RESET = DEF_AVG_RESET
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   input  logic [TAG_W-1:0]        miss_tag,
   input  logic                    fill_valid,
   input  logic [TAG_W-1:0]        fill_tag,
   input  logic [STAMP_W-1:0]      now_cycle,
   output logic [AVG_W-1:0]        avg_latency,
   output logic [DEPTH-1:0]        tbl_valid,
   output logic [DEPTH*TAG_W-1:0]  tbl_tags
);

   if ((WIN < 2) || ((WIN & (WIN - 1)) != 0)) begin : g_bad_win
      $error("window length must be a power of two of at least 2");
   end
   if (LAT_W > STAMP_W) begin : g_bad_lat
      $error("sample width cannot exceed stamp width");
   end
   if (AVG_W < LAT_W) begin : g_bad_avg
      $error("average output narrower than a sample");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("table needs at least two slots");
   end

   logic               fill_hit;
   logic [STAMP_W-1:0] fill_stamp;
   logic [STAMP_W-1:0] elapsed;
   logic [LAT_W-1:0]   lat_sample;
   logic               win_full;

   lat_est_miss_table #(
      .TAG_W   (TAG_W),
      .STAMP_W (STAMP_W),
      .DEPTH   (DEPTH)
   ) table_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_tag   (miss_tag),
      .fill_valid (fill_valid),
      .fill_tag   (fill_tag),
      .now_cycle  (now_cycle),
      .fill_hit   (fill_hit),
      .fill_stamp (fill_stamp),
      .ent_valid  (tbl_valid),
      .ent_tags   (tbl_tags)
   );

   assign elapsed    = now_cycle - fill_stamp;
   assign lat_sample = elapsed[LAT_W-1:0];

   lat_est_window #(
      .LAT_W     (LAT_W),
      .WIN       (WIN),
      .AVG_W     (AVG_W),
      .AVG_RESET (AVG_RESET)
   ) window_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (fill_hit),
      .sample (lat_sample),
      .avg    (avg_latency),
      .full   (win_full)
   );

endmodule

// File: rtl/lat_est_chk.sv
module lat_est_chk #(
   parameter int unsigned TAG_W     = 16,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned AVG_W     = 16,
   parameter int unsigned AVG_RESET = 100
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    miss_valid,
   input logic [TAG_W-1:0]        miss_tag,
   input logic                    fill_valid,
   input logic [TAG_W-1:0]        fill_tag,
   input logic [AVG_W-1:0]        avg_latency,
   input logic [DEPTH-1:0]        tbl_valid,
   input logic [DEPTH*TAG_W-1:0]  tbl_tags,
   input logic                    push,
   input logic                    win_full
);

   function automatic logic holds(input logic [DEPTH-1:0] v,
                                  input logic [DEPTH*TAG_W-1:0] t,
                                  input logic [TAG_W-1:0] k);
      logic r;
      r = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (v[i] && (t[i*TAG_W +: TAG_W] == k)) r = 1'b1;
      return r;
   endfunction

   function automatic logic twice(input logic [DEPTH-1:0] v,
                                  input logic [DEPTH*TAG_W-1:0] t);
      logic r;
      r = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         for (int j = i + 1; j < DEPTH; j++)
            if (v[i] && v[j] && (t[i*TAG_W +: TAG_W] == t[j*TAG_W +: TAG_W])) r = 1'b1;
      return r;
   endfunction

   logic miss_new, fill_known;
   assign miss_new   = miss_valid && !holds(tbl_valid, tbl_tags, miss_tag);
   assign fill_known = fill_valid && holds(tbl_valid, tbl_tags, fill_tag);

   assert_default_avg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_full |-> (avg_latency == AVG_W'(AVG_RESET)));

   assert_packed_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((tbl_valid & (tbl_valid + 1'b1)) == '0));

   assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !twice(tbl_valid, tbl_tags));

   assert_unknown_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !miss_valid && !fill_known) |=> ($stable(tbl_valid) && $stable(tbl_tags)));

   assert_avg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(avg_latency));

   assert_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_new && !fill_valid && !tbl_valid[DEPTH-1])
      |=> ($countones(tbl_valid) == $past($countones(tbl_valid)) + 1));

   assert_stay_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_new && !fill_valid && tbl_valid[DEPTH-1]) |=> (&tbl_valid));

   assert_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_known && !miss_valid)
      |=> ($countones(tbl_valid) + 1 == $past($countones(tbl_valid))));

   assert_fill_before_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_known && miss_valid && (miss_tag == fill_tag))
      |=> ($stable(tbl_valid) && holds(tbl_valid, tbl_tags, $past(miss_tag))));

endmodule

bind lat_est_top lat_est_chk #(
   .TAG_W     (TAG_W),
   .DEPTH     (DEPTH),
   .AVG_W     (AVG_W),
   .AVG_RESET (AVG_RESET)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .miss_valid  (miss_valid),
   .miss_tag    (miss_tag),
   .fill_valid  (fill_valid),
   .fill_tag    (fill_tag),
   .avg_latency (avg_latency),
   .tbl_valid   (tbl_valid),
   .tbl_tags    (tbl_tags),
   .push        (fill_hit),
   .win_full    (win_full)
);

// File: tb/lat_est_top_tb_top.sv
`timescale 1ns/1ps
module lat_est_top_tb_top;

   localparam int DEPTH = 16;
   localparam int TAG_W = 16;
   localparam int WIN   = 32;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   miss_valid = 1'b0;
   logic [TAG_W-1:0]       miss_tag = '0;
   logic                   fill_valid = 1'b0;
   logic [TAG_W-1:0]       fill_tag = '0;
   logic [15:0]            now_cycle = '0;
   logic [15:0]            avg_latency;
   logic [DEPTH-1:0]       tbl_valid;
   logic [DEPTH*TAG_W-1:0] tbl_tags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   int unsigned mt_q[$];
   int unsigned ms_q[$];
   int unsigned win_q[$];
   int unsigned exp_avg = 100;

   always #5 clk = ~clk;

   lat_est_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_valid  (miss_valid),
      .miss_tag    (miss_tag),
      .fill_valid  (fill_valid),
      .fill_tag    (fill_tag),
      .now_cycle   (now_cycle),
      .avg_latency (avg_latency),
      .tbl_valid   (tbl_valid),
      .tbl_tags    (tbl_tags)
   );

   task automatic check_all(input string req);
      logic [DEPTH-1:0]       ev;
      logic [DEPTH*TAG_W-1:0] et, mt;
      ev = '0; et = '0; mt = '0;
      for (int i = 0; i < mt_q.size(); i++) begin
         ev[i] = 1'b1;
         et[i*TAG_W +: TAG_W] = mt_q[i][15:0];
         mt[i*TAG_W +: TAG_W] = '1;
      end
      checks++;
      if (tbl_valid !== ev || (tbl_tags & mt) !== et) begin
         errors++;
         $display("FAIL %s table valid=%h tags=%h expected valid=%h tags=%h",
                  req, tbl_valid, tbl_tags & mt, ev, et);
      end
      checks++;
      if (avg_latency !== exp_avg[15:0]) begin
         errors++;
         $display("FAIL %s avg_latency actual=%0d expected=%0d", req, avg_latency, exp_avg);
      end
   endtask

   // one event cycle; called with time just after a falling edge
   task automatic op(input bit mv, input int unsigned mtg, input bit fv,
                     input int unsigned ftg, input int unsigned t, input string req);
      int idx;
      int unsigned lat, sum;
      miss_valid = mv; miss_tag = mtg[15:0];
      fill_valid = fv; fill_tag = ftg[15:0];
      now_cycle  = t[15:0];
      // fill first
      if (fv) begin
         idx = -1;
         for (int i = 0; i < mt_q.size(); i++)
            if (idx < 0 && mt_q[i] == (ftg & 16'hFFFF)) idx = i;
         if (idx >= 0) begin
            lat = ((t - ms_q[idx]) & 32'hFFFF) & 32'h3FF;
            mt_q.delete(idx);
            ms_q.delete(idx);
            win_q.push_back(lat);
            if (win_q.size() > WIN) void'(win_q.pop_front());
            if (win_q.size() == WIN) begin
               sum = 0;
               foreach (win_q[k]) sum += win_q[k];
               exp_avg = sum >> 5;
            end
         end
      end
      if (mv) begin
         idx = -1;
         for (int i = 0; i < mt_q.size(); i++)
            if (mt_q[i] == (mtg & 16'hFFFF)) idx = i;
         if (idx < 0) begin
            if (mt_q.size() == DEPTH) begin
               void'(mt_q.pop_front());
               void'(ms_q.pop_front());
            end
            mt_q.push_back(mtg & 16'hFFFF);
            ms_q.push_back(t & 16'hFFFF);
         end
      end
      @(negedge clk);
      miss_valid = 1'b0;
      fill_valid = 1'b0;
      check_all(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      for (int k = 0; k < 5; k++) op(1, 16'h0100 + k, 0, 0, 10 * k, "R2");
      op(1, 16'h0102, 0, 0, 200, "R3");
      op(0, 0, 1, 16'h0777, 210, "R6");
      op(0, 0, 1, 16'h0102, 250, "R5");      // sample 230
      op(0, 0, 1, 16'h0100, 16'h0500, "R7"); // 1280 -> 256
      for (int k = 0; k < 20; k++) op(1, 16'h0200 + k, 0, 0, 300 + k, "R4");
      op(1, 16'h0210, 1, 16'h0210, 400, "R10");
      op(1, 16'h0300, 1, 16'h0211, 410, "R10");
      op(0, 0, 1, 16'h0210, 450, "R10");      // re-stamped at 400 -> 50
      op(1, 16'h0400, 0, 0, 16'hFFF0, "R7");
      op(0, 0, 1, 16'h0400, 16'h0020, "R7");  // wraps to 48

      for (int k = 0; k < 100; k++) begin
         int unsigned t0, lk;
         t0 = (k * 1500) & 16'hFFFF;
         lk = (k * 97 + 13) % 1024;
         op(1, 16'h1000 + k, 0, 0, t0, "R8");
         op(0, 0, 1, 16'h1000 + k, t0 + lk, (k < 40) ? "R8" : "R9");
      end

      for (int k = 0; k < 400; k++)
         op(1, k % 24, (k % 3) == 0, (k * 7) % 24, k * 13 + 5, "R10");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule